// File: doc/BRIEF.md
# Guarded Configuration Register Slave

This block is a two-wire serial slave that owns one configuration byte. It oversamples the bus clock and data lines with the system clock. It recognises START and STOP conditions and shifts bytes in and out, pulling the data line low through an open-drain enable when it acknowledges or sends a zero. Only a slave byte whose upper nibble carries a fixed device-type code addresses it. A register address of 1FFh must follow. The ninth address bit travels in bit 1 of the slave byte, and bit 0 of the slave byte is the read/write flag (1 = read).

The register cannot be changed in a single transaction. Software first writes 02h to set a volatile write-enable latch. It then writes 06h to set a second volatile latch, the register-enable latch. Only then is a data byte with bit 2 clear and bit 1 set taken into the stored fields. The stored fields are updated only when the STOP condition arrives, and at that moment a one-clock commit strobe marks the store. The slave then refuses new transactions for a fixed number of clocks. A random read returns the whole byte: the stored fields plus both latches.

Top module: `regWriteGuard`

## Requirements
- R1: After reset, every stored field is 0, both latches are 0, the data-line pull enable is inactive and the commit strobe is low. A read then returns 00h.
- R2: A slave byte is acknowledged only when its bits 7:4 equal 1011. Any other slave byte is not acknowledged, and the slave acknowledges no further byte until the next START.
- R3: After the slave byte, the register address is 9 bits: bit 1 of the slave byte followed by the address byte. The address byte is acknowledged only when this address is 1FFh. Otherwise the slave acknowledges nothing more in the transaction and the data has no effect.
- R4: A write of data 02h followed by STOP sets the write-enable latch, which reads back in bit 1.
- R5: A write of data 06h followed by STOP sets the register-enable latch (read bit 2) only when the write-enable latch is already set. Otherwise it has no effect.
- R6: With both latches set, a data byte D with D[2]=0 and D[1]=1 stores D[7:3] and D[0] on STOP. The register-enable latch clears and the write-enable latch stays set. The outputs are pupSel={D[7],D[0]}, wdSel=D[6:5] and bpSel=D[4:3].
- R7: A data byte written while the latches do not allow it is still acknowledged, but it leaves the stored fields and the latches unchanged.
- R8: Only the first data byte of a write is acknowledged. Later bytes of the same write are not acknowledged and are not used.
- R9: A data byte takes effect only on STOP. A START or repeated START that comes first discards it.
- R10: commitPulse is high for exactly one clock for each STOP that completes a valid store, and at no other time.
- R11: For BUSY_CYCLES clocks after a store, every slave byte is not acknowledged. After that interval, slave bytes are acknowledged again.
- R12: A read returns exactly one byte, most significant bit first, laid out as {PUP1, WD1, WD0, BP1, BP0, register-enable, write-enable, PUP0}. The slave releases the data line in the ninth clock. A STOP or a START ends the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial bus clock |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaDrvLow | output | 1 | Open-drain enable; 1 pulls the data line low |
| pupSel | output | 2 | Stored power-up field {bit7, bit0} |
| wdSel | output | 2 | Stored watchdog field {bit6, bit5} |
| bpSel | output | 2 | Stored block-protect field {bit4, bit3} |
| commitPulse | output | 1 | One-clock strobe when a store is made |

## Verification
The assertions assume that every low and high phase of the bus clock lasts longer than the three-clock synchroniser latency. They also assume that the master moves the data line only while the clock is low, apart from START and STOP, and that the bus stays idle for some clocks after a STOP. Under these conditions the slave's own data-line changes fall inside clock-low phases, and a store always coincides with an idle bus. The bench master keeps each clock phase at eight system clocks and places its data changes four clocks into the low phase. It never contends with the slave in a way that would fake a START or STOP.

// File: rtl/regGuardPkg.sv
package regGuardPkg;

  // Strobes the bus control hands to the register datapath
  typedef struct packed {
    logic startSeen;   // START or repeated START detected
    logic stopSeen;    // STOP detected
    logic capture;     // first data byte of a write is complete
  } busStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_IGNORE
  } busStateT;

endpackage

// File: rtl/regGuardCtrl.sv
module regGuardCtrl
  import regGuardPkg::*;
#(
  parameter logic [3:0] PREAMBLE = 4'hB,
  parameter logic [8:0] REG_ADDR = 9'h1FF
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            scl,
  input  logic            sdaIn,
  input  logic            busy,
  input  logic [7:0]      readByte,
  output logic            sdaDrvLow,
  output busStrobeT       strobe,
  output logic [7:0]      rxByte
);

  logic [1:0] sclSync, sdaSync;
  logic       sclQ, sdaQ;
  logic       sclNow, sdaNow;
  logic       sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], scl};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclNow   = sclSync[1];
  assign sdaNow   = sdaSync[1];
  assign sclRise  = sclNow & ~sclQ;
  assign sclFall  = ~sclNow & sclQ;
  assign startDet = sclNow & sclQ & sdaQ & ~sdaNow;
  assign stopDet  = sclNow & sclQ & ~sdaQ & sdaNow;

  busStateT   state, ackNext, nextNow;
  logic [3:0] bitCnt;
  logic [7:0] shReg, txReg;
  logic       addrHigh, firstData, sdaLow, ackNow;
  logic       byteDone;

  assign byteDone = sclFall && (bitCnt == 4'd8);

  // Acknowledge decision for the byte that just completed
  always_comb begin
    ackNow  = 1'b0;
    nextNow = ST_IGNORE;
    case (state)
      ST_DEV: if (shReg[7:4] == PREAMBLE && !busy) begin
        ackNow  = 1'b1;
        nextNow = shReg[0] ? ST_RDATA : ST_ADDR;
      end
      ST_ADDR: if ({addrHigh, shReg} == REG_ADDR) begin
        ackNow  = 1'b1;
        nextNow = ST_WDATA;
      end
      ST_WDATA: begin
        ackNow  = firstData;
        nextNow = ST_WDATA;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackNext   <= ST_IDLE;
      bitCnt    <= 4'd0;
      shReg     <= 8'd0;
      txReg     <= 8'd0;
      addrHigh  <= 1'b0;
      firstData <= 1'b0;
      sdaLow    <= 1'b0;
    end else if (startDet) begin
      state  <= ST_DEV;
      bitCnt <= 4'd0;
      sdaLow <= 1'b0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      sdaLow <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            shReg  <= {shReg[6:0], sdaNow};
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCnt  <= 4'd0;
            sdaLow  <= ackNow;
            ackNext <= nextNow;
            state   <= ST_ACK;
            if (state == ST_DEV)   addrHigh  <= shReg[1];
            if (state == ST_ADDR)  firstData <= 1'b1;
            if (state == ST_WDATA) firstData <= 1'b0;
          end
        end
        ST_ACK: if (sclFall) begin
          state <= ackNext;
          if (ackNext == ST_RDATA) begin
            txReg  <= readByte;
            sdaLow <= ~readByte[7];
          end else begin
            sdaLow <= 1'b0;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              sdaLow <= 1'b0;
              state  <= ST_IGNORE;
            end else begin
              sdaLow <= ~txReg[6];
              txReg  <= {txReg[6:0], 1'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaDrvLow        = sdaLow;
  assign rxByte           = shReg;
  assign strobe.startSeen = startDet;
  assign strobe.stopSeen  = stopDet;
  assign strobe.capture   = (state == ST_WDATA) && byteDone && firstData
                            && !startDet && !stopDet;

endmodule

// File: rtl/regGuardData.sv
module regGuardData
  import regGuardPkg::*;
#(
  parameter int BUSY_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  busStrobeT  strobe,
  input  logic [7:0] rxByte,
  output logic       busy,
  output logic [7:0] readByte,
  output logic [1:0] pupSel,
  output logic [1:0] wdSel,
  output logic [1:0] bpSel,
  output logic       commitPulse
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES);

  localparam logic [7:0] SET_WEL  = 8'h02;
  localparam logic [7:0] SET_RWEL = 8'h06;

  logic [5:0]        fieldsQ;   // {b7,b6,b5,b4,b3,b0}
  logic              welQ, rwelQ, pendValid, commitQ;
  logic [7:0]        pendByte;
  logic [BUSY_W-1:0] busyCnt;
  logic              storeOk;

  assign storeOk = welQ && rwelQ && (pendByte[2:1] == 2'b01);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldsQ   <= '0;
      welQ      <= 1'b0;
      rwelQ     <= 1'b0;
      pendValid <= 1'b0;
      pendByte  <= 8'd0;
      commitQ   <= 1'b0;
      busyCnt   <= '0;
    end else begin
      commitQ <= 1'b0;
      if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
      if (strobe.capture) begin
        pendValid <= 1'b1;
        pendByte  <= rxByte;
      end else if (strobe.startSeen) begin
        pendValid <= 1'b0;
      end else if (strobe.stopSeen && pendValid) begin
        pendValid <= 1'b0;
        if (storeOk) begin
          fieldsQ <= {pendByte[7:3], pendByte[0]};
          rwelQ   <= 1'b0;
          commitQ <= 1'b1;
          busyCnt <= BUSY_LOAD;
        end else if (pendByte == SET_RWEL && welQ) begin
          rwelQ <= 1'b1;
        end else if (pendByte == SET_WEL) begin
          welQ <= 1'b1;
        end
      end
    end
  end

  assign busy        = (busyCnt != '0);
  assign readByte    = {fieldsQ[5:1], rwelQ, welQ, fieldsQ[0]};
  assign pupSel      = {fieldsQ[5], fieldsQ[0]};
  assign wdSel       = fieldsQ[4:3];
  assign bpSel       = fieldsQ[2:1];
  assign commitPulse = commitQ;

endmodule

// File: rtl/regWriteGuard.sv
module regWriteGuard
  import regGuardPkg::*;
#(
  parameter int         BUSY_CYCLES = 256,
  parameter logic [3:0] PREAMBLE    = 4'hB,
  parameter logic [8:0] REG_ADDR    = 9'h1FF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  output logic       sdaDrvLow,
  output logic [1:0] pupSel,
  output logic [1:0] wdSel,
  output logic [1:0] bpSel,
  output logic       commitPulse
);

  busStrobeT  strobe;
  logic [7:0] rxByte, readByte;
  logic       busy;

  regGuardCtrl #(.PREAMBLE(PREAMBLE), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn),
    .busy(busy), .readByte(readByte),
    .sdaDrvLow(sdaDrvLow), .strobe(strobe), .rxByte(rxByte)
  );

  regGuardData #(.BUSY_CYCLES(BUSY_CYCLES)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .busy(busy), .readByte(readByte),
    .pupSel(pupSel), .wdSel(wdSel), .bpSel(bpSel),
    .commitPulse(commitPulse)
  );

endmodule

// File: rtl/regGuardChecker.sv
module regGuardChecker #(
  parameter int BUSY_CYCLES = 256
) (
  input logic       clk,
  input logic       rstN,
  input logic       scl,
  input logic       sdaIn,
  input logic       sdaDrvLow,
  input logic [1:0] pupSel,
  input logic [1:0] wdSel,
  input logic [1:0] bpSel,
  input logic       commitPulse
);

  localparam int HOLD_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD =
    HOLD_W'((BUSY_CYCLES > 2) ? BUSY_CYCLES - 2 : 0);

  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (commitPulse)     holdCnt <= HOLD_LOAD;
    else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end

  // R10: the strobe never lasts longer than one clock
  assert_commit_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse);

  // R9: a store only happens with the bus idle after a STOP
  assert_commit_on_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> (scl && sdaIn));

  // R7: the stored fields move only together with a commit
  assert_fields_only_on_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({pupSel, wdSel, bpSel}) |-> commitPulse);

  // R11: during the hold-off window the slave never pulls the line
  assert_busy_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt != '0) |-> !sdaDrvLow);

  // R12: the slave changes its data drive only while the clock is low
  assert_sda_change_scl_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> !scl);

endmodule

bind regWriteGuard regGuardChecker #(.BUSY_CYCLES(BUSY_CYCLES)) u_checker (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .sdaDrvLow(sdaDrvLow),
  .pupSel(pupSel), .wdSel(wdSel), .bpSel(bpSel), .commitPulse(commitPulse)
);

// File: tb/test_regWriteGuard.sv
module test_regWriteGuard;

  localparam int BUSY = 300;
  localparam logic [7:0] DEV_WR = 8'hB2;
  localparam logic [7:0] DEV_RD = 8'hB3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaMLow = 1'b0;
  logic sdaLine;
  logic sdaDrvLow, commitPulse, prevCommit;
  logic [1:0] pupSel, wdSel, bpSel;

  int testCount = 0;
  int failCount = 0;
  int commitCount = 0;
  int widthErr = 0;
  int expCommits = 0;
  logic [7:0] expImg = 8'h00;
  logic expWel = 1'b0, expRwel = 1'b0;

  always #5 clk = ~clk;

  assign sdaLine = !(sdaMLow || sdaDrvLow);

  regWriteGuard #(.BUSY_CYCLES(BUSY)) i_regWriteGuard (
    .clk(clk), .rstN(rstN), .scl(sclM), .sdaIn(sdaLine),
    .sdaDrvLow(sdaDrvLow), .pupSel(pupSel), .wdSel(wdSel), .bpSel(bpSel),
    .commitPulse(commitPulse)
  );

  always @(posedge clk) begin
    prevCommit <= commitPulse;
    if (commitPulse) commitCount++;
    if (commitPulse && prevCommit) widthErr++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaMLow = 1'b0; waitQ(4); sclM = 1'b1; waitQ(4);
    sdaMLow = 1'b1; waitQ(4); sclM = 1'b0;
  endtask

  task automatic stopCond();
    sdaMLow = 1'b1; waitQ(4); sclM = 1'b1; waitQ(4);
    sdaMLow = 1'b0; waitQ(8);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      waitQ(4); sdaMLow = !b[i]; waitQ(4); sclM = 1'b1; waitQ(8); sclM = 1'b0;
    end
    waitQ(4); sdaMLow = 1'b0; waitQ(4); sclM = 1'b1; waitQ(4);
    acked = !sdaLine; waitQ(4); sclM = 1'b0;
  endtask

  task automatic recvByte(output logic [7:0] b, output logic released);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      waitQ(4); sdaMLow = 1'b0; waitQ(4); sclM = 1'b1; waitQ(4);
      b = {b[6:0], sdaLine}; waitQ(4); sclM = 1'b0;
    end
    waitQ(4); sdaMLow = 1'b0; waitQ(4); sclM = 1'b1; waitQ(4);
    released = !sdaDrvLow; waitQ(4); sclM = 1'b0;
  endtask

  function automatic logic [7:0] expRead();
    return {expImg[7:3], expRwel, expWel, expImg[0]};
  endfunction

  // Requirement model of one completed write followed by STOP
  function automatic void model(input logic [7:0] d);
    if (expWel && expRwel && d[2:1] == 2'b01) begin
      expImg  = {d[7:3], 3'b000} | {7'd0, d[0]};
      expRwel = 1'b0;
      expCommits++;
    end else if (d == 8'h06 && expWel) begin
      expRwel = 1'b1;
    end else if (d == 8'h02) begin
      expWel = 1'b1;
    end
  endfunction

  task automatic doWrite(input logic [7:0] d, input string req);
    logic a;
    startCond();
    sendByte(DEV_WR, a); check({req, " dev ack"}, a, 1);
    sendByte(8'hFF, a);  check({req, " addr ack"}, a, 1);
    sendByte(d, a);      check({req, " data ack"}, a, 1);
    stopCond();
    model(d);
  endtask

  task automatic doRead(input string req);
    logic a, rel;
    logic [7:0] v;
    startCond();
    sendByte(DEV_WR, a); check({req, " R12 dev ack"}, a, 1);
    sendByte(8'hFF, a);  check({req, " R12 addr ack"}, a, 1);
    startCond();
    sendByte(DEV_RD, a); check({req, " R12 read dev ack"}, a, 1);
    recvByte(v, rel);
    check({req, " R12 read value"}, v, expRead());
    check({req, " R12 released in 9th clock"}, rel, 1);
    stopCond();
  endtask

  task automatic checkFields(input string req);
    check({req, " R6 pupSel"}, pupSel, {expImg[7], expImg[0]});
    check({req, " R6 wdSel"}, wdSel, expImg[6:5]);
    check({req, " R6 bpSel"}, bpSel, expImg[4:3]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testCount++; failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic a;
    logic rel;
    logic [7:0] v;
    logic [5:0] f;
    logic [7:0] d;

    waitQ(5);
    check("R1 sda released in reset", sdaDrvLow, 0);
    check("R1 commit low in reset", commitPulse, 0);
    rstN = 1'b1;
    waitQ(5);
    check("R1 fields after reset", {pupSel, wdSel, bpSel}, 0);
    check("R1 sda released", sdaDrvLow, 0);
    doRead("R1 reset read");

    // R2: sweep every preamble nibble
    for (int n = 0; n < 16; n++) begin
      startCond();
      sendByte({4'(n), 4'b0010}, a);
      check("R2 preamble ack", a, (n == 11) ? 1 : 0);
      sendByte(8'hFF, a);
      check("R2 follow-up byte", a, (n == 11) ? 1 : 0);
      if (n != 11) begin
        sendByte(8'h02, a);
        check("R2 ignored data", a, 0);
      end
      stopCond();
    end
    doRead("R2 no effect");

    // R3: wrong ninth bit, then a sweep of address bytes
    startCond();
    sendByte(8'hB0, a); check("R3 dev ack", a, 1);
    sendByte(8'hFF, a); check("R3 addr 0FFh rejected", a, 0);
    sendByte(8'h02, a); check("R3 data ignored", a, 0);
    stopCond();
    for (int k = 0; k < 15; k++) begin
      startCond();
      sendByte(DEV_WR, a);
      sendByte(8'(k * 17), a); check("R3 addr rejected", a, 0);
      sendByte(8'h02, a);      check("R3 data ignored", a, 0);
      stopCond();
    end
    doRead("R3 latch untouched");

    // R7 and R5 without permission
    doWrite(8'hFB, "R7 unlatched write");
    doRead("R7 unchanged");
    check("R7 no commit", commitCount, 0);
    doWrite(8'h06, "R5 without WEL");
    doRead("R5 no effect");

    doWrite(8'h02, "R4 set WEL");
    doRead("R4 WEL read");
    doWrite(8'h06, "R5 set RWEL");
    doRead("R5 RWEL read");

    // R6, R10, R11
    doWrite(8'hFB, "R6 store");
    check("R10 one commit", commitCount, 1);
    checkFields("R6 first store");
    startCond();
    sendByte(DEV_WR, a); check("R11 busy nack", a, 0);
    stopCond();
    waitQ(BUSY + 40);
    startCond();
    sendByte(DEV_WR, a); check("R11 ack after busy", a, 1);
    stopCond();
    doRead("R6 readback");

    // R6 sweep of field patterns
    for (int k = 0; k < 16; k++) begin
      f = 6'((k * 37 + 5) % 64);
      d = {f[5:1], 1'b0, 1'b1, f[0]};
      doWrite(8'h06, "R5 rearm");
      doWrite(d, "R6 sweep store");
      checkFields("R6 sweep");
      check("R10 sweep commit count", commitCount, expCommits);
      waitQ(BUSY + 40);
      doRead("R6 sweep read");
    end

    // R8: second data byte refused
    doWrite(8'h06, "R8 arm");
    startCond();
    sendByte(DEV_WR, a); sendByte(8'hFF, a);
    sendByte(8'h4B, a);  check("R8 first data ack", a, 1);
    sendByte(8'hB3, a);  check("R8 second data nack", a, 0);
    stopCond();
    model(8'h4B);
    checkFields("R8 first byte used");
    waitQ(BUSY + 40);
    doRead("R8 readback");

    // R9: repeated START discards; R12 read ended by START
    doWrite(8'h06, "R9 arm");
    startCond();
    sendByte(DEV_WR, a); sendByte(8'hFF, a);
    sendByte(8'hAB, a);  check("R9 data ack", a, 1);
    startCond();
    sendByte(DEV_RD, a); check("R9 read dev ack", a, 1);
    recvByte(v, rel);
    check("R9 value unchanged", v, expRead());
    check("R12 released", rel, 1);
    startCond();
    sendByte(DEV_RD, a); check("R12 read after START", a, 1);
    recvByte(v, rel);
    check("R12 second read value", v, expRead());
    stopCond();
    check("R9 no commit", commitCount, expCommits);
    checkFields("R9 fields unchanged");

    check("R10 pulse width", widthErr, 0);
    check("R10 total commits", commitCount, expCommits);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule